// File: doc/BRIEF.md
# Interleaved Round-Reuse AES-128 Encryptor

This block encrypts 128-bit blocks under a 128-bit key with the AES-128 cipher, running all ten rounds through one shared round datapath. A register splits that datapath in two halves: byte substitution with row rotation on one side, column mixing with key addition on the other. Two independent blocks therefore share the hardware in alternate cycles. Each block advances one half-round per cycle, and its round keys are derived one step at a time as it goes.

A block is offered on a valid/ready port together with its key and a one-bit label. The block lands in whichever of the two slots is about to enter the first half of the datapath. It is accepted only if that slot is empty or is finishing its last round in that same cycle. The ciphertext leaves on a one-cycle valid pulse, carrying the label given at load. Data vectors are big-endian byte strings: byte 0 sits in bits [127:120]. The state is filled column by column, so byte index 4*c+r is row r of column c.

Top module: `aes128_interleaved_enc`

## Requirements
- R1: While reset is held and in the first cycle after it, `ct_valid` is 0 and `blk_ready` is 1. A reset applied while blocks are in flight discards them, so no ciphertext appears for those blocks afterwards.
- R2: Two known-answer vectors are encrypted correctly. Key 000102030405060708090a0b0c0d0e0f with text 00112233445566778899aabbccddeeff gives 69c4e0d86a7b0430d8cdb78070b4c55a. Key 2b7e151628aed2a6abf7158809cf4f3c with text 3243f6a8885a308d313198a2e0370734 gives 3925841d02dc09fbdc118597196a0b32.
- R3: For any key and text, `ct_data` is the AES-128 encryption of the accepted text under the accepted key. This covers an initial key addition, nine full rounds, and a last round without column mixing.
- R4: A block accepted at a clock edge (`blk_valid` and `blk_ready` both 1) produces `ct_valid` exactly 20 clock edges later.
- R5: `ct_tag` equals the `blk_tag` sampled when that block was accepted.
- R6: Every accepted block yields exactly one single-cycle `ct_valid` pulse, and no pulse appears without an accepted block. At most two blocks are in flight.
- R7: When both slots are busy and neither is in its last round, `blk_ready` is 0. An offer made in such a cycle has no effect on any later output. With offers held from idle, `blk_ready` is low for 18 consecutive cycles after the second acceptance.
- R8: Under continuous offers the block sustains two blocks per 20 cycles: 128 streamed blocks span 1261 cycles from first to last acceptance. Ciphertexts leave in acceptance order.
- R9: With both slots idle, `blk_ready` is 1 in every cycle. A slot accepts a new block in the same cycle that it completes its previous one, so a third acceptance follows the first by exactly 20 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_valid | input | 1 | Offer of a block this cycle |
| blk_ready | output | 1 | The slot aligned for loading can take the offer |
| blk_text | input | 128 | Plaintext block, byte 0 in bits [127:120] |
| blk_key | input | 128 | Cipher key, byte 0 in bits [127:120] |
| blk_tag | input | 1 | Label returned with the ciphertext |
| ct_valid | output | 1 | One-cycle pulse: ciphertext present |
| ct_data | output | 128 | Ciphertext block |
| ct_tag | output | 1 | Label of the block being reported |

## Verification
A corrupted slot state, round key or round counter shows up on the ciphertext port. It appears exactly 20 cycles after that block's acceptance, because every byte diffuses through the remaining rounds. A slip in the phase or slot bookkeeping shows up sooner and more visibly. The ciphertext may come out of order or with the wrong label. The valid pulse may land off the 20-cycle mark. Or `blk_ready` may deviate from its fixed pattern of two accepts followed by 18 refusals. The sweeps over single-bit texts and single-bit keys reach every S-box input lane and every key-schedule byte in both slots.

// File: rtl/aes_ilv_pkg.sv
package aes_ilv_pkg;

    localparam int BLK_W      = 128;
    localparam int BYTE_W     = 8;
    localparam int NROW       = 4;
    localparam int NCOL       = 4;
    localparam int COL_W      = NROW * BYTE_W;
    localparam int NUM_ROUNDS = 10;
    localparam int RND_W      = $clog2(NUM_ROUNDS + 2);
    localparam int N_SLOTS    = 2;
    localparam logic [BYTE_W-1:0] RCON_FIRST = 8'h01;
    localparam logic [BYTE_W-1:0] GF_POLY    = 8'h1b;
    localparam logic [BYTE_W-1:0] AFF_CONST  = 8'h63;

    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic                               phase;
        logic [N_SLOTS-1:0]                 busy;
        logic [N_SLOTS-1:0]                 tag;
        logic [N_SLOTS-1:0][RND_W-1:0]      rnd;
        logic [N_SLOTS-1:0][BYTE_W-1:0]     rcon;
        logic [N_SLOTS-1:0][BLK_W-1:0]      st;
        logic [N_SLOTS-1:0][BLK_W-1:0]      rk;
        blk_t                               mid;
        logic                               ovld;
        logic                               otag;
        blk_t                               odata;
    } ilv_regs_t;

    function automatic byte_t xtime(input byte_t x);
        return {x[BYTE_W-2:0], 1'b0} ^ (x[BYTE_W-1] ? GF_POLY : '0);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // multiplicative inverse as a^254 (maps 0 to 0)
    function automatic byte_t gf_inv(input byte_t a);
        byte_t p2, p3, p6, p7, p14, p15, p30, p31, p62, p63, p126, p127;
        p2   = gf_mul(a, a);
        p3   = gf_mul(p2, a);
        p6   = gf_mul(p3, p3);
        p7   = gf_mul(p6, a);
        p14  = gf_mul(p7, p7);
        p15  = gf_mul(p14, a);
        p30  = gf_mul(p15, p15);
        p31  = gf_mul(p30, a);
        p62  = gf_mul(p31, p31);
        p63  = gf_mul(p62, a);
        p126 = gf_mul(p63, p63);
        p127 = gf_mul(p126, a);
        return gf_mul(p127, p127);
    endfunction

    function automatic byte_t rotl8(input byte_t v, input int n);
        return byte_t'((v << n) | (v >> (BYTE_W - n)));
    endfunction

    function automatic byte_t sbox(input byte_t x);
        byte_t v;
        v = gf_inv(x);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ AFF_CONST;
    endfunction

endpackage

// File: rtl/aes_ilv_subshift.sv
// First half-round: byte substitution followed by row rotation.
module aes_ilv_subshift
    import aes_ilv_pkg::*;
(
    input  blk_t din,
    output blk_t dout
);
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        for (genvar r = 0; r < NROW; r++) begin : g_row
            localparam int DST = NROW * c + r;
            localparam int SRC = NROW * ((c + r) % NCOL) + r;
            assign dout[BLK_W-1-BYTE_W*DST -: BYTE_W] = sbox(din[BLK_W-1-BYTE_W*SRC -: BYTE_W]);
        end
    end
endmodule

// File: rtl/aes_ilv_mixadd.sv
// Second half-round: column mixing (skipped in the last round), then key addition.
module aes_ilv_mixadd
    import aes_ilv_pkg::*;
(
    input  blk_t din,
    input  blk_t rkey,
    input  logic skip_mix,
    output blk_t dout
);
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        localparam int HI = BLK_W - 1 - COL_W * c;
        byte_t a0, a1, a2, a3;
        logic [COL_W-1:0] mixed;
        assign a0 = din[HI -: BYTE_W];
        assign a1 = din[HI-BYTE_W -: BYTE_W];
        assign a2 = din[HI-2*BYTE_W -: BYTE_W];
        assign a3 = din[HI-3*BYTE_W -: BYTE_W];
        assign mixed = {xtime(a0 ^ a1) ^ a1 ^ a2 ^ a3,
                        xtime(a1 ^ a2) ^ a2 ^ a3 ^ a0,
                        xtime(a2 ^ a3) ^ a3 ^ a0 ^ a1,
                        xtime(a3 ^ a0) ^ a0 ^ a1 ^ a2};
        assign dout[HI -: COL_W] = (skip_mix ? din[HI -: COL_W] : mixed) ^ rkey[HI -: COL_W];
    end
endmodule

// File: rtl/aes_ilv_keystep.sv
// One step of the AES-128 key schedule.
module aes_ilv_keystep
    import aes_ilv_pkg::*;
(
    input  blk_t  kin,
    input  byte_t rcon,
    output blk_t  kout
);
    logic [COL_W-1:0] last_w, rot_w, mix_w;
    logic [COL_W-1:0] n0, n1, n2, n3;

    assign last_w = kin[COL_W-1:0];
    assign rot_w  = {last_w[COL_W-BYTE_W-1:0], last_w[COL_W-1 -: BYTE_W]};

    for (genvar b = 0; b < NROW; b++) begin : g_sub
        localparam int HI = COL_W - 1 - BYTE_W * b;
        if (b == 0) begin : g_rc
            assign mix_w[HI -: BYTE_W] = sbox(rot_w[HI -: BYTE_W]) ^ rcon;
        end else begin : g_plain
            assign mix_w[HI -: BYTE_W] = sbox(rot_w[HI -: BYTE_W]);
        end
    end

    assign n0   = kin[BLK_W-1 -: COL_W] ^ mix_w;
    assign n1   = kin[BLK_W-1-COL_W -: COL_W] ^ n0;
    assign n2   = kin[BLK_W-1-2*COL_W -: COL_W] ^ n1;
    assign n3   = last_w ^ n2;
    assign kout = {n0, n1, n2, n3};
endmodule

// File: rtl/aes128_interleaved_enc.sv
module aes128_interleaved_enc
    import aes_ilv_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         blk_valid,
    output logic         blk_ready,
    input  logic [127:0] blk_text,
    input  logic [127:0] blk_key,
    input  logic         blk_tag,
    output logic         ct_valid,
    output logic [127:0] ct_data,
    output logic         ct_tag
);
    ilv_regs_t r_q, r_d;

    logic  a_sel, b_sel;
    logic  last_rnd;
    blk_t  sub_in, sub_out, key_nxt, mix_out;

    // slot a runs the first half this cycle, slot b the second half
    assign a_sel    = r_q.phase;
    assign b_sel    = ~r_q.phase;
    assign sub_in   = r_q.st[a_sel];
    assign last_rnd = r_q.rnd[b_sel] == RND_W'(NUM_ROUNDS);

    aes_ilv_subshift u_sub (
        .din  (sub_in),
        .dout (sub_out)
    );

    aes_ilv_keystep u_key (
        .kin  (r_q.rk[b_sel]),
        .rcon (r_q.rcon[b_sel]),
        .kout (key_nxt)
    );

    aes_ilv_mixadd u_mix (
        .din      (r_q.mid),
        .rkey     (key_nxt),
        .skip_mix (last_rnd),
        .dout     (mix_out)
    );

    assign blk_ready = ~r_q.busy[b_sel] | last_rnd;

    always_comb begin
        r_d       = r_q;
        r_d.phase = ~r_q.phase;
        r_d.mid   = sub_out;
        r_d.ovld  = 1'b0;

        if (r_q.busy[b_sel]) begin
            r_d.st[b_sel]   = mix_out;
            r_d.rk[b_sel]   = key_nxt;
            r_d.rcon[b_sel] = xtime(r_q.rcon[b_sel]);
            r_d.rnd[b_sel]  = r_q.rnd[b_sel] + RND_W'(1);
            if (last_rnd) begin
                r_d.busy[b_sel] = 1'b0;
                r_d.ovld        = 1'b1;
                r_d.odata       = mix_out;
                r_d.otag        = r_q.tag[b_sel];
            end
        end

        if (blk_valid && blk_ready) begin
            r_d.st[b_sel]   = blk_text ^ blk_key;
            r_d.rk[b_sel]   = blk_key;
            r_d.rcon[b_sel] = RCON_FIRST;
            r_d.rnd[b_sel]  = RND_W'(1);
            r_d.busy[b_sel] = 1'b1;
            r_d.tag[b_sel]  = blk_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ct_valid = r_q.ovld;
    assign ct_data  = r_q.odata;
    assign ct_tag   = r_q.otag;
endmodule

// File: rtl/aes128_interleaved_enc_chk.sv
module aes128_interleaved_enc_chk (
    input logic clk,
    input logic rst_n,
    input logic blk_valid,
    input logic blk_ready,
    input logic blk_tag,
    input logic ct_valid,
    input logic ct_tag
);
    localparam int LAT = 20;

    logic            acc;
    logic [LAT:0]    acc_hist, tag_hist;
    logic [2:0]      cnt_q, live;

    assign acc  = blk_valid && blk_ready;
    assign live = cnt_q - {2'b00, ct_valid};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_hist <= '0;
            tag_hist <= '0;
            cnt_q    <= '0;
        end else begin
            acc_hist <= {acc_hist[LAT-1:0], acc};
            tag_hist <= {tag_hist[LAT-1:0], blk_tag};
            cnt_q    <= cnt_q + {2'b00, acc} - {2'b00, ct_valid};
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !ct_valid);
    // R1
    reset_ready_chk: assert property (@(posedge clk) !rst_n |=> blk_ready);
    // R4
    latency_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hist[LAT] |-> ct_valid);
    // R6
    no_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ct_valid |-> acc_hist[LAT]);
    // R5
    tag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ct_valid |-> ct_tag == tag_hist[LAT]);
    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live <= 3'd2);
    // R7
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 3'd2 && blk_ready) |=> ct_valid);
    // R9
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 3'd0) |-> blk_ready);
endmodule

bind aes128_interleaved_enc aes128_interleaved_enc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_valid (blk_valid),
    .blk_ready (blk_ready),
    .blk_tag   (blk_tag),
    .ct_valid  (ct_valid),
    .ct_tag    (ct_tag)
);

// File: tb/aes128_interleaved_enc_test.sv
module aes128_interleaved_enc_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         blk_valid = 1'b0;
    logic         blk_ready;
    logic [127:0] blk_text = '0;
    logic [127:0] blk_key = '0;
    logic         blk_tag = 1'b0;
    logic         ct_valid;
    logic [127:0] ct_data;
    logic         ct_tag;

    always #5 clk = ~clk;

    aes128_interleaved_enc uut (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ready(blk_ready),
        .blk_text(blk_text), .blk_key(blk_key), .blk_tag(blk_tag),
        .ct_valid(ct_valid), .ct_data(ct_data), .ct_tag(ct_tag)
    );

    typedef struct packed {
        logic [127:0] ct;
        logic         tag;
        logic         kat;
        logic [31:0]  step;
    } exp_t;

    exp_t        expq[$];
    logic [7:0]  sb[256];
    int          nchk = 0;
    int          nfail = 0;
    logic [31:0] stepno = 0;
    logic [31:0] rng = 32'h1234_5678;
    bit          finished = 0;

    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [127:0] ref_enc(input logic [127:0] k, input logic [127:0] p);
        logic [7:0] s[16], w[16], t[16];
        logic [7:0] rc, a0, a1, a2, a3;
        logic [127:0] res;
        rc = 8'h01;
        for (int i = 0; i < 16; i++) begin
            w[i] = k[127-8*i -: 8];
            s[i] = p[127-8*i -: 8] ^ w[i];
        end
        for (int r = 1; r <= 10; r++) begin
            w[0] = w[0] ^ sb[w[13]] ^ rc;
            w[1] = w[1] ^ sb[w[14]];
            w[2] = w[2] ^ sb[w[15]];
            w[3] = w[3] ^ sb[w[12]];
            for (int i = 4; i < 16; i++) w[i] = w[i] ^ w[i-4];
            rc = gm(rc, 8'h02);
            for (int i = 0; i < 16; i++) t[i] = sb[s[i]];
            for (int c = 0; c < 4; c++)
                for (int rr = 0; rr < 4; rr++) s[4*c+rr] = t[4*((c+rr)%4)+rr];
            if (r < 10) begin
                for (int c = 0; c < 4; c++) begin
                    a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
                    s[4*c]   = gm(a0,8'h02) ^ gm(a1,8'h03) ^ a2 ^ a3;
                    s[4*c+1] = a0 ^ gm(a1,8'h02) ^ gm(a2,8'h03) ^ a3;
                    s[4*c+2] = a0 ^ a1 ^ gm(a2,8'h02) ^ gm(a3,8'h03);
                    s[4*c+3] = gm(a0,8'h03) ^ a1 ^ a2 ^ gm(a3,8'h02);
                end
            end
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[i];
        end
        for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
        return res;
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic draw128(output logic [127:0] v);
        for (int i = 0; i < 4; i++) begin
            rng = nxt(rng);
            v[32*i +: 32] = rng;
        end
    endtask

    task automatic chk(input string req, input bit ok, input logic [127:0] act, input logic [127:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h (step %0d)", req, act, expv, stepno);
        end
    endtask

    task automatic mon();
        exp_t e;
        if (ct_valid) begin
            if (expq.size() == 0) begin
                chk("R6", 1'b0, ct_data, '0);
            end else begin
                e = expq.pop_front();
                chk(e.kat ? "R2" : "R3", ct_data == e.ct, ct_data, e.ct);
                chk("R5", ct_tag == e.tag, 128'(ct_tag), 128'(e.tag));
                // accepted at the edge after step e.step; seen at the step after edge +20
                chk("R4", stepno - e.step == 32'd21, 128'(stepno - e.step), 128'd21);
            end
        end
    endtask

    task automatic tick();
        @(negedge clk);
        stepno++;
        mon();
    endtask

    // present one offer this cycle; returns whether it was taken
    task automatic offer(input logic [127:0] k, input logic [127:0] p, input logic tg,
                         input bit kat, input logic [127:0] kat_ct, output bit took);
        blk_valid = 1'b1;
        blk_key   = k;
        blk_text  = p;
        blk_tag   = tg;
        took      = blk_ready;
        if (took) expq.push_back({kat ? kat_ct : ref_enc(k, p), tg, kat, stepno});
        tick();
    endtask

    task automatic drain();
        blk_valid = 1'b0;
        for (int i = 0; i < 60 && expq.size() > 0; i++) tick();
        if (expq.size() > 0) begin
            chk("R6", 1'b0, 128'(expq.size()), '0);
            expq.delete();
        end
    endtask

    task automatic stream(input int mode, input int n, output logic [31:0] first_s, output logic [31:0] last_s);
        int idx = 0;
        bit took;
        logic [127:0] k, p;
        first_s = '0;
        last_s  = '0;
        while (idx < n) begin
            if (mode == 0) begin
                k = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
                p = 128'd1 << idx;
            end else if (mode == 1) begin
                k = 128'd1 << idx;
                p = '0;
            end else begin
                draw128(k);
                draw128(p);
            end
            if (mode == 2 && rng[3:2] == 2'b00) begin
                blk_valid = 1'b0;
                tick();
            end else begin
                if (idx == 0) first_s = stepno;
                last_s = stepno;
                offer(k, p, idx[0] ^ rng[7], 1'b0, '0, took);
                if (took) idx++;
                else if (idx == 0) first_s = '0;
            end
        end
        blk_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL R8: watchdog expired, actual %0d steps expected fewer", stepno);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        bit took;
        logic [31:0] f_s, l_s, first_acc, third_acc;
        logic [127:0] k, p;
        int nacc, lows;
        logic [7:0] iv, sv;

        for (int x = 0; x < 256; x++) begin
            iv = '0;
            for (int y = 1; y < 256; y++) if (gm(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
            for (int b = 0; b < 8; b++)
                sv[b] = iv[b] ^ iv[(b+4)%8] ^ iv[(b+5)%8] ^ iv[(b+6)%8] ^ iv[(b+7)%8] ^ ((8'h63 >> b) & 8'h01) != 0;
            sb[x] = sv;
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", ct_valid == 1'b0, 128'(ct_valid), 128'd0);
        chk("R1", blk_ready == 1'b1, 128'(blk_ready), 128'd1);
        rst_n = 1'b1;
        tick();
        chk("R1", ct_valid == 1'b0 && blk_ready == 1'b1, {ct_valid, blk_ready}, 128'd1);

        // R9: both slots idle, ready every cycle
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R9", blk_ready == 1'b1, 128'(blk_ready), 128'd1);
        end

        // R2: known-answer vectors
        took = 0;
        while (!took) offer(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
                            1'b1, 1'b1, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, took);
        blk_valid = 1'b0;
        drain();
        took = 0;
        while (!took) offer(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
                            1'b0, 1'b1, 128'h3925841d02dc09fbdc118597196a0b32, took);
        blk_valid = 1'b0;
        drain();

        // R7 / R9: held offers from idle; refused offers carry fresh data each cycle
        nacc = 0; lows = 0; first_acc = '0; third_acc = '0;
        for (int j = 0; j < 24; j++) begin
            draw128(k);
            draw128(p);
            if (blk_ready) begin
                if (nacc == 0) first_acc = stepno;
                if (nacc == 2) third_acc = stepno;
                nacc++;
            end else if (nacc >= 1 && stepno <= first_acc + 19) begin
                lows++;
            end
            offer(k, p, rng[0], 1'b0, '0, took);
        end
        blk_valid = 1'b0;
        chk("R7", lows == 18, 128'(lows), 128'd18);
        chk("R9", third_acc == first_acc + 20, 128'(third_acc - first_acc), 128'd20);
        drain();

        // R8 / R3: streamed single-bit texts
        stream(0, 128, f_s, l_s);
        chk("R8", l_s - f_s == 32'd1261, 128'(l_s - f_s), 128'd1261);
        drain();

        // R3: streamed single-bit keys
        stream(1, 128, f_s, l_s);
        drain();

        // R3 / R7: pseudo-random data with gaps
        stream(2, 200, f_s, l_s);
        drain();

        // R1: reset with blocks in flight discards them
        offer(128'h1, 128'h2, 1'b0, 1'b0, '0, took);
        offer(128'h3, 128'h4, 1'b1, 1'b0, '0, took);
        blk_valid = 1'b0;
        repeat (5) tick();
        rst_n = 1'b0;
        expq.delete();
        tick();
        chk("R1", blk_ready == 1'b1 && ct_valid == 1'b0, {ct_valid, blk_ready}, 128'd1);
        rst_n = 1'b1;
        repeat (30) tick();
        chk("R1", expq.size() == 0, 128'(expq.size()), 128'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule